// File: doc/BRIEF.md
# External Load-Locked Address Register

This block is the backup reservation for load-locked / store-conditional synchronization. It sits in a processor-to-system-bus interface. When the processor issues a load-locked, the block records the 32-byte aligned block that holds the address and raises a reservation flag. The flag goes straight back to the processor, which samples it while fill data arrives from the bus.

Every bus transaction is snooped. A write to the reserved block drops the reservation. So does an exclusive read or an exclusive exchange aimed at it. An exchange carries two addresses, a victim-write address and a read address. The two share their low 18 bits, and only the read address is checked. The processor can also drop the reservation itself, when a store-conditional completes or through an explicit clear.

Top module: `ext_lock_reg`

## Requirements
- R1: One cycle after `ll_req_i` is high, `lock_flag_o` is 1 and `lock_blk_o` holds `ll_addr_i[39:5]`.
- R2: Snoop matching uses address bits [39:5] only. Byte-offset bits [4:0] never affect a hit.
- R3: A valid snoop whose command bits [1:0] are 2'b10 (write, with bit 2 either value) and whose `bus_addr_i` is in the reserved block clears `lock_flag_o` one cycle later.
- R4: A valid snoop with command 3'b101 (exclusive read) whose `bus_addr_i` is in the reserved block clears the flag one cycle later.
- R5: For command 3'b111 (exclusive exchange), the compared address is `{bus_rd_hi_i, bus_addr_i[17:0]}`. A hit clears the flag. The victim address on `bus_addr_i[39:18]` is never compared.
- R6: Commands 3'b000 (no-op), 3'b001 (read), 3'b011 (plain exchange) and 3'b100 never clear the flag. A snoop with `bus_vld_i` low is ignored.
- R7: `sc_done_i` or `clr_i` high clears the flag one cycle later.
- R8: When a load-locked arrives in the same cycle as any clearing event, the clearing is applied first. The new reservation then stands: the flag is 1 and the address is the new one.
- R9: While `rst_n` is low, `lock_flag_o` is 0 and `lock_blk_o` is 0.
- R10: `lock_blk_o` changes only in the cycle after a load-locked request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_req_i | input | 1 | Load-locked request from the processor |
| ll_addr_i | input | 40 | Byte address of the load-locked |
| sc_done_i | input | 1 | Store-conditional completed |
| clr_i | input | 1 | Explicit reservation clear from the processor |
| bus_vld_i | input | 1 | Snooped bus command valid this cycle |
| bus_cmd_i | input | 3 | Bit 2 exclusive; bits [1:0] 00 no-op, 01 read, 10 write, 11 exchange |
| bus_addr_i | input | 40 | Write/read address, or exchange victim address |
| bus_rd_hi_i | input | 22 | Exchange read address bits [39:18] |
| lock_flag_o | output | 1 | Reservation flag to the processor |
| lock_blk_o | output | 35 | Reserved block address (bits [39:5]) |

## Verification
Two kinds of bad internal state are possible. A stale flag leaves `lock_flag_o` high after a clearing snoop, and a wrongly dropped flag reads low. Either shows at the port on the very next cycle. A wrong captured block shows on `lock_blk_o` in the cycle after the load-locked. It also shows up as a hit that does not clear, or a miss that does clear, on the first snoop that straddles the block boundary. The risky corners are the exchange address split, the exclusive bit on reads versus exchanges, and a load-locked colliding with a snoop or a processor clear. The bench drives each of these and compares both outputs on every cycle.

// File: rtl/ext_lock_pkg.sv
package ext_lock_pkg;

  typedef enum logic [1:0] {
    KIND_NOP   = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_XCHG  = 2'b11
  } bus_kind_e;

  typedef struct packed {
    logic      excl;
    bus_kind_e kind;
  } bus_cmd_t;

  // A snooped command may drop a reservation when it writes the block
  // or claims it exclusively through a read or an exchange.
  function automatic logic cmd_can_kill(input bus_cmd_t c);
    logic k;
    k = 1'b0;
    if (c.kind == KIND_WRITE)
      k = 1'b1;
    else if (c.excl && (c.kind == KIND_READ || c.kind == KIND_XCHG))
      k = 1'b1;
    return k;
  endfunction

endpackage

// File: rtl/ext_lock_snoop_dec.sv
module ext_lock_snoop_dec
  import ext_lock_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int OFF_W   = 5,
  parameter int SHARE_W = 18
) (
  input  logic                      vld_i,
  input  logic [2:0]                cmd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [ADDR_W-SHARE_W-1:0] rd_hi_i,
  output logic                      kill_cand_o,
  output logic [ADDR_W-OFF_W-1:0]   cmp_blk_o
);

  bus_cmd_t          cmd;
  logic [ADDR_W-1:0] cmp_addr;
  logic              unused_offset_bits;

  assign cmd = bus_cmd_t'(cmd_i);

  always_comb begin
    if (cmd.kind == KIND_XCHG)
      cmp_addr = {rd_hi_i, addr_i[SHARE_W-1:0]};
    else
      cmp_addr = addr_i;
  end

  assign kill_cand_o        = vld_i & cmd_can_kill(cmd);
  assign cmp_blk_o          = cmp_addr[ADDR_W-1:OFF_W];
  assign unused_offset_bits = ^cmp_addr[OFF_W-1:0];

endmodule

// File: rtl/ext_lock_blk_match.sv
module ext_lock_blk_match #(
  parameter int BLK_W = 35
) (
  input  logic [BLK_W-1:0] a_blk_i,
  input  logic [BLK_W-1:0] b_blk_i,
  output logic             hit_o
);

  assign hit_o = (a_blk_i == b_blk_i);

endmodule

// File: rtl/ext_lock_state.sv
module ext_lock_state #(
  parameter int BLK_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ll_i,
  input  logic [BLK_W-1:0] ll_blk_i,
  input  logic             kill_i,
  output logic             flag_o,
  output logic [BLK_W-1:0] blk_o
);

  logic             flag_q, flag_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             blk_en;

  // Clearing is applied first; a simultaneous load-locked then re-arms.
  always_comb begin
    flag_d = flag_q & ~kill_i;
    if (ll_i)
      flag_d = 1'b1;
    blk_en = ll_i;
    blk_d  = ll_blk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      blk_q <= '0;
    else if (blk_en)
      blk_q <= blk_d;
  end

  assign flag_o = flag_q;
  assign blk_o  = blk_q;

endmodule

// File: rtl/ext_lock_reg.sv
module ext_lock_reg #(
  parameter int ADDR_W  = 40,
  parameter int OFF_W   = 5,
  parameter int SHARE_W = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ll_req_i,
  input  logic [ADDR_W-1:0]         ll_addr_i,
  input  logic                      sc_done_i,
  input  logic                      clr_i,
  input  logic                      bus_vld_i,
  input  logic [2:0]                bus_cmd_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [ADDR_W-SHARE_W-1:0] bus_rd_hi_i,
  output logic                      lock_flag_o,
  output logic [ADDR_W-OFF_W-1:0]   lock_blk_o
);

  localparam int BLK_W = ADDR_W - OFF_W;

  logic             kill_cand;
  logic [BLK_W-1:0] snoop_blk;
  logic             snoop_hit;
  logic             kill;
  logic [BLK_W-1:0] cur_blk;
  logic             unused_ll_offset;

  ext_lock_snoop_dec #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SHARE_W(SHARE_W)
  ) u_dec (
    .vld_i      (bus_vld_i),
    .cmd_i      (bus_cmd_i),
    .addr_i     (bus_addr_i),
    .rd_hi_i    (bus_rd_hi_i),
    .kill_cand_o(kill_cand),
    .cmp_blk_o  (snoop_blk)
  );

  ext_lock_blk_match #(
    .BLK_W(BLK_W)
  ) u_match (
    .a_blk_i(snoop_blk),
    .b_blk_i(cur_blk),
    .hit_o  (snoop_hit)
  );

  assign kill = (kill_cand & snoop_hit) | sc_done_i | clr_i;

  ext_lock_state #(
    .BLK_W(BLK_W)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .ll_i    (ll_req_i),
    .ll_blk_i(ll_addr_i[ADDR_W-1:OFF_W]),
    .kill_i  (kill),
    .flag_o  (lock_flag_o),
    .blk_o   (cur_blk)
  );

  assign lock_blk_o       = cur_blk;
  assign unused_ll_offset = ^ll_addr_i[OFF_W-1:0];

endmodule

// File: rtl/ext_lock_reg_chk.sv
module ext_lock_reg_chk #(
  parameter int ADDR_W  = 40,
  parameter int OFF_W   = 5,
  parameter int SHARE_W = 18
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ll_req_i,
  input logic [ADDR_W-1:0]         ll_addr_i,
  input logic                      sc_done_i,
  input logic                      clr_i,
  input logic                      bus_vld_i,
  input logic [2:0]                bus_cmd_i,
  input logic [ADDR_W-1:0]         bus_addr_i,
  input logic [ADDR_W-SHARE_W-1:0] bus_rd_hi_i,
  input logic                      lock_flag_o,
  input logic [ADDR_W-OFF_W-1:0]   lock_blk_o
);

  logic wr_hit, xrd_hit, xx_hit, benign;

  assign wr_hit  = bus_vld_i && bus_cmd_i[1:0] == 2'b10 &&
                   bus_addr_i[ADDR_W-1:OFF_W] == lock_blk_o;
  assign xrd_hit = bus_vld_i && bus_cmd_i == 3'b101 &&
                   bus_addr_i[ADDR_W-1:OFF_W] == lock_blk_o;
  assign xx_hit  = bus_vld_i && bus_cmd_i == 3'b111 &&
                   {bus_rd_hi_i, bus_addr_i[SHARE_W-1:OFF_W]} == lock_blk_o;
  assign benign  = !bus_vld_i || bus_cmd_i == 3'b000 || bus_cmd_i == 3'b001 ||
                   bus_cmd_i == 3'b011 || bus_cmd_i == 3'b100;

  a_r1_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ll_req_i |=> lock_flag_o && lock_blk_o == $past(ll_addr_i[ADDR_W-1:OFF_W]));

  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !ll_req_i) |=> !lock_flag_o);

  a_r4_xread_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xrd_hit && !ll_req_i) |=> !lock_flag_o);

  a_r5_xxchg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xx_hit && !ll_req_i) |=> !lock_flag_o);

  a_r6_benign_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flag_o && benign && !sc_done_i && !clr_i) |=> lock_flag_o);

  a_r7_proc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((sc_done_i || clr_i) && !ll_req_i) |=> !lock_flag_o);

  a_r10_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ll_req_i |=> $stable(lock_blk_o));

  a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_flag_o && !ll_req_i) |=> !lock_flag_o);

endmodule

bind ext_lock_reg ext_lock_reg_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .SHARE_W(SHARE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ll_req_i   (ll_req_i),
  .ll_addr_i  (ll_addr_i),
  .sc_done_i  (sc_done_i),
  .clr_i      (clr_i),
  .bus_vld_i  (bus_vld_i),
  .bus_cmd_i  (bus_cmd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rd_hi_i(bus_rd_hi_i),
  .lock_flag_o(lock_flag_o),
  .lock_blk_o (lock_blk_o)
);

// File: tb/tb_ext_lock_reg.sv
module tb_ext_lock_reg;

  localparam int AW = 40;
  localparam int OW = 5;
  localparam int SW = 18;
  localparam int BW = AW - OW;
  localparam int HW = AW - SW;

  logic          clk;
  logic          rst_n;
  logic          ll_req_i;
  logic [AW-1:0] ll_addr_i;
  logic          sc_done_i;
  logic          clr_i;
  logic          bus_vld_i;
  logic [2:0]    bus_cmd_i;
  logic [AW-1:0] bus_addr_i;
  logic [HW-1:0] bus_rd_hi_i;
  logic          lock_flag_o;
  logic [BW-1:0] lock_blk_o;

  ext_lock_reg #(.ADDR_W(AW), .OFF_W(OW), .SHARE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .ll_req_i(ll_req_i), .ll_addr_i(ll_addr_i),
    .sc_done_i(sc_done_i), .clr_i(clr_i), .bus_vld_i(bus_vld_i),
    .bus_cmd_i(bus_cmd_i), .bus_addr_i(bus_addr_i), .bus_rd_hi_i(bus_rd_hi_i),
    .lock_flag_o(lock_flag_o), .lock_blk_o(lock_blk_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic          flag;
    logic [BW-1:0] blk;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  int            n_chk = 0;
  int            n_err = 0;
  logic          m_flag;
  logic [BW-1:0] m_blk;
  bit            done = 1'b0;

  // Monitor: one expected entry per driven cycle, compared after the edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (lock_flag_o !== e.flag || lock_blk_o !== e.blk) begin
        n_err++;
        $display("FAIL %s: flag=%0b blk=%h expected flag=%0b blk=%h",
                 e.tag, lock_flag_o, lock_blk_o, e.flag, e.blk);
      end
    end
  end

  // Driver: applies one cycle of stimulus and pushes the model result.
  task automatic step(input logic ll, input logic [AW-1:0] lla,
                      input logic sc, input logic cl,
                      input logic bv, input logic [2:0] cmd,
                      input logic [AW-1:0] ba, input logic [HW-1:0] rh,
                      input string tag);
    logic [AW-1:0] cmp;
    logic          can, kill;
    exp_t          e;
    @(negedge clk);
    ll_req_i = ll; ll_addr_i = lla; sc_done_i = sc; clr_i = cl;
    bus_vld_i = bv; bus_cmd_i = cmd; bus_addr_i = ba; bus_rd_hi_i = rh;
    cmp  = (cmd[1:0] == 2'b11) ? {rh, ba[SW-1:0]} : ba;
    can  = (cmd[1:0] == 2'b10) || cmd == 3'b101 || cmd == 3'b111;
    kill = sc || cl || (bv && can && cmp[AW-1:OW] == m_blk);
    if (kill) m_flag = 1'b0;
    if (ll) begin m_flag = 1'b1; m_blk = lla[AW-1:OW]; end
    e.flag = m_flag; e.blk = m_blk; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [AW-1:0] ba,
                       input logic [HW-1:0] rh, input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, cmd, ba, rh, tag);
  endtask

  task automatic lock(input logic [AW-1:0] a, input string tag);
    step(1'b1, a, 1'b0, 1'b0, 1'b0, 3'b000, '0, '0, tag);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, b;
    a = 40'h12_3456_7840;
    b = 40'h0A_BCDE_F000;
    rst_n = 1'b0; ll_req_i = 1'b0; ll_addr_i = '0; sc_done_i = 1'b0;
    clr_i = 1'b0; bus_vld_i = 1'b0; bus_cmd_i = '0; bus_addr_i = '0;
    bus_rd_hi_i = '0; m_flag = 1'b0; m_blk = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (lock_flag_o !== 1'b0 || lock_blk_o !== '0) begin
      n_err++;
      $display("FAIL R9 reset: flag=%0b blk=%h expected flag=0 blk=0",
               lock_flag_o, lock_blk_o);
    end
    rst_n = 1'b1;

    lock(a + 40'h7, "R1 load-locked sets");
    snoop(3'b010, a + 40'h20, '0, "R2 write next block misses");
    snoop(3'b010, a + 40'h1F, '0, "R3 write same block clears");
    lock(a, "R1 relock");
    snoop(3'b001, a, '0, "R6 plain read keeps");
    snoop(3'b000, a, '0, "R6 no-op keeps");
    snoop(3'b100, a, '0, "R6 cmd 100 keeps");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 3'b010, a, '0, "R6 invalid write ignored");
    snoop(3'b011, a, a[AW-1:SW], "R6 plain exchange keeps");
    snoop(3'b110, a - 40'h1, '0, "R2 excl write prev block misses");
    snoop(3'b110, a + 40'h3, '0, "R3 excl write clears");
    lock(a, "R1 relock");
    snoop(3'b101, a + 40'h20, '0, "R4 xread other block keeps");
    snoop(3'b101, a + 40'h11, '0, "R4 xread clears");
    lock(a, "R1 relock");
    snoop(3'b111, a, a[AW-1:SW] ^ 22'h1, "R5 xxchg victim-only match keeps");
    snoop(3'b111, {a[AW-1:SW] ^ 22'h3, a[SW-1:0]}, a[AW-1:SW],
          "R5 xxchg read address clears");
    lock(a, "R1 relock");
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, 3'b000, '0, '0, "R7 sc_done clears");
    lock(a, "R1 relock");
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 3'b000, '0, '0, "R7 clr clears");
    lock(a, "R1 relock");
    step(1'b1, b, 1'b0, 1'b0, 1'b1, 3'b010, a, '0, "R8 lock B over clearing write");
    step(1'b1, b + 40'h4, 1'b0, 1'b0, 1'b1, 3'b101, b, '0, "R8 relock with xread hit");
    step(1'b1, a, 1'b0, 1'b1, 1'b0, 3'b000, '0, '0, "R8 lock with clr");
    snoop(3'b010, b, '0, "R10 address holds on miss");
    snoop(3'b010, a, '0, "R3 write clears again");
    snoop(3'b000, '0, '0, "R10 idle holds");
    @(negedge clk);
    bus_vld_i = 1'b0; ll_req_i = 1'b0; sc_done_i = 1'b0; clr_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule